// File: doc/BRIEF.md
# Inline-Header Transmit Buffer Engine

This block is the device-side reader of a circular transmit buffer. The host places packet records in a local byte-addressed memory. Each record is a 4-byte length header followed directly by the payload. The host then moves a write index, counted in 32-bit words, past the new record. The engine follows with its own read pointer. It fetches the length from the header and sends the payload out as a byte stream with valid/ready handshaking. Reads wrap at the end of the buffer, and the engine moves on to the next 4-byte-aligned record.

Every record that finishes, including an empty one, leaves a completion entry in a separate status ring. An entry holds an update flag, the payload size and a success bit. The host reads entries through a small read port and acknowledges each one by clearing its flag. If the slot that the next completion would use has not been acknowledged yet, the engine does not begin another record.

Top module: `txbuf_engine`

## Requirements
- R1: After reset, st_valid is low and every status entry reads back with its update flag clear.
- R2: A record is begun only while the word part of the read pointer (pointer divided by 4) differs from wr_idx. When the two are equal, no byte is offered on the stream.
- R3: In a record header, byte offset 0 is the low byte and offset 1 the high byte of a 16-bit payload length, and offsets 2 and 3 have no effect. The payload bytes start at header + 4 and are offered in buffer order, one per handshake, with st_last high on the final byte only.
- R4: While st_valid is high and st_ready is low, st_valid, st_data and st_last keep their values into the next cycle.
- R5: Payload addresses wrap modulo the buffer size, so a payload may continue at offset 0 partway through.
- R6: After a record, the next header is read at (pointer + length + 7) with its two low bits cleared, modulo the buffer size.
- R7: Each finished record writes the status slot at the engine's status index. The slot gets update flag 1, size equal to the header length, and success equal to tx_ok sampled on the final byte's handshake. The index then advances modulo the ring depth.
- R8: A record of length 0 sends no stream byte and writes a completion with size 0 and success 0.
- R9: While the update flag of the slot at the engine's status index is set, no new record is begun. Clearing that flag through sr_clr lets the waiting record proceed.
- R10: sr_rd_flag, sr_rd_size and sr_rd_ok show the entry selected by sr_rd_idx one clock after it is applied. A pulse on sr_clr clears the update flag of entry sr_clr_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host byte write strobe into the buffer |
| host_addr | input | log2(BUF_BYTES) | Byte address of the host write |
| host_data | input | 8 | Byte written by the host |
| wr_idx | input | log2(BUF_BYTES)-2 | Host write index in 32-bit words |
| st_data | output | 8 | Payload byte |
| st_valid | output | 1 | Payload byte is valid |
| st_ready | input | 1 | Sink accepts the byte |
| st_last | output | 1 | Final byte of the record |
| tx_ok | input | 1 | Success flag captured with the final byte |
| sr_clr | input | 1 | Clear the update flag of one status entry |
| sr_clr_idx | input | log2(STAT_DEPTH) | Entry to clear |
| sr_rd_idx | input | log2(STAT_DEPTH) | Entry to read |
| sr_rd_flag | output | 1 | Update flag of the read entry |
| sr_rd_size | output | 16 | Size field of the read entry |
| sr_rd_ok | output | 1 | Success field of the read entry |

## Verification
The bench builds the engine with a 64-byte buffer and a 4-entry status ring instead of the 8192-byte and 64-entry defaults. With the 64-byte buffer, a handful of short records is enough to place one header in the last word, so that its payload starts at offset 0. A later record then wraps partway through its payload. With the 4-entry ring, four completions fill the ring. The fifth record stalls until the host clears a slot, and its completion then lands back in slot 0, which covers both the stall and the index wrap within a few hundred cycles.

// File: rtl/txe_pkg.sv
package txe_pkg;
  localparam int SIZE_W = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR0,
    S_HDR1,
    S_STREAM,
    S_DONE
  } rd_state_t;

  typedef struct packed {
    logic              ok;
    logic [SIZE_W-1:0] size;
  } stat_rec_t;
endpackage

// File: rtl/txe_byte_ram.sv
module txe_byte_ram #(
  parameter int BYTES = 8192,
  localparam int AW = $clog2(BYTES),
  localparam int WORDS = BYTES / 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [3:0][7:0] lane_q;
  logic [1:0]      sel_q;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && (waddr[1:0] == 2'(l)))
        lane_mem[waddr[AW-1:2]] <= wdata;
      if (re)
        lane_q[l] <= lane_mem[raddr[AW-1:2]];
    end
  end

  always_ff @(posedge clk) begin
    if (re)
      sel_q <= raddr[1:0];
  end

  assign rdata = lane_q[sel_q];
endmodule

// File: rtl/txe_status_ring.sv
module txe_status_ring
  import txe_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int SW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eng_we,
  input  logic [SW-1:0]    eng_idx,
  input  stat_rec_t        eng_rec,
  input  logic             clr,
  input  logic [SW-1:0]    clr_idx,
  input  logic [SW-1:0]    rd_idx,
  output logic             rd_flag,
  output stat_rec_t        rd_rec,
  output logic [DEPTH-1:0] flags
);
  stat_rec_t rec_mem [DEPTH];
  logic [DEPTH-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (eng_we && (eng_idx == SW'(i)))
          flag_q[i] <= 1'b1;
        else if (clr && (clr_idx == SW'(i)))
          flag_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (eng_we)
      rec_mem[eng_idx] <= eng_rec;
    rd_rec <= rec_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_flag <= 1'b0;
    else     rd_flag <= flag_q[rd_idx];
  end

  assign flags = flag_q;
endmodule

// File: rtl/txe_reader.sv
module txe_reader
  import txe_pkg::*;
#(
  parameter int BYTES = 8192,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(BYTES),
  localparam int SW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-3:0]     wr_idx,
  input  logic              slot_busy,
  output logic              ram_re,
  output logic [AW-1:0]     ram_raddr,
  input  logic [7:0]        ram_rdata,
  output logic              st_valid,
  input  logic              st_ready,
  output logic              st_last,
  input  logic              tx_ok,
  output logic              stat_we,
  output logic [SW-1:0]     stat_idx,
  output stat_rec_t         stat_rec,
  output logic [AW-1:0]     ptr,
  output logic [SIZE_W-1:0] pkt_len,
  output logic              busy
);
  rd_state_t         state;
  logic [7:0]        len_lo;
  logic [SIZE_W-1:0] len_r;
  logic [SIZE_W-1:0] fetch_left;
  logic [AW-1:0]     cur;
  logic              ok_r;
  logic              go;
  logic              adv;
  logic [SIZE_W-1:0] len_now;
  logic [AW-1:0]     ptr_sum;

  assign go      = (ptr[AW-1:2] != wr_idx) && !slot_busy;
  assign adv     = !st_valid || st_ready;
  assign len_now = {ram_rdata, len_lo};
  assign ptr_sum = ptr + AW'(len_r) + AW'(7);

  always_comb begin
    ram_re    = 1'b0;
    ram_raddr = ptr;
    case (state)
      S_IDLE: begin
        if (go) begin
          ram_re    = 1'b1;
          ram_raddr = ptr;
        end
      end
      S_HDR0: begin
        ram_re    = 1'b1;
        ram_raddr = ptr + AW'(1);
      end
      S_STREAM: begin
        if (adv && (fetch_left != '0)) begin
          ram_re    = 1'b1;
          ram_raddr = cur;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ptr        <= '0;
      stat_idx   <= '0;
      st_valid   <= 1'b0;
      st_last    <= 1'b0;
      len_lo     <= '0;
      len_r      <= '0;
      fetch_left <= '0;
      cur        <= '0;
      ok_r       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (go) state <= S_HDR0;
        end
        S_HDR0: begin
          len_lo <= ram_rdata;
          state  <= S_HDR1;
        end
        S_HDR1: begin
          len_r      <= len_now;
          fetch_left <= len_now;
          cur        <= ptr + AW'(4);
          ok_r       <= 1'b0;
          state      <= (len_now == '0) ? S_DONE : S_STREAM;
        end
        S_STREAM: begin
          if (st_valid && st_ready && st_last) begin
            ok_r     <= tx_ok;
            st_valid <= 1'b0;
            st_last  <= 1'b0;
            state    <= S_DONE;
          end else if (adv) begin
            if (fetch_left != '0) begin
              cur        <= cur + AW'(1);
              fetch_left <= fetch_left - SIZE_W'(1);
              st_valid   <= 1'b1;
              st_last    <= (fetch_left == SIZE_W'(1));
            end else begin
              st_valid <= 1'b0;
            end
          end
        end
        S_DONE: begin
          ptr      <= {ptr_sum[AW-1:2], 2'b00};
          stat_idx <= stat_idx + SW'(1);
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign stat_we       = (state == S_DONE);
  assign stat_rec.ok   = ok_r;
  assign stat_rec.size = len_r;
  assign pkt_len       = len_r;
  assign busy          = (state != S_IDLE);
endmodule

// File: rtl/txbuf_engine.sv
module txbuf_engine
  import txe_pkg::*;
#(
  parameter int BUF_BYTES  = 8192,
  parameter int STAT_DEPTH = 64,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int SW = $clog2(STAT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [7:0]        host_data,
  input  logic [AW-3:0]     wr_idx,
  output logic [7:0]        st_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic              st_last,
  input  logic              tx_ok,
  input  logic              sr_clr,
  input  logic [SW-1:0]     sr_clr_idx,
  input  logic [SW-1:0]     sr_rd_idx,
  output logic              sr_rd_flag,
  output logic [SIZE_W-1:0] sr_rd_size,
  output logic              sr_rd_ok
);
  logic                  ram_re;
  logic [AW-1:0]         ram_raddr;
  logic [7:0]            ram_rdata;
  logic                  stat_we;
  logic [SW-1:0]         stat_idx;
  stat_rec_t             stat_rec;
  stat_rec_t             rd_rec;
  logic [STAT_DEPTH-1:0] stat_flags;
  logic [AW-1:0]         rd_ptr;
  logic [SIZE_W-1:0]     pkt_len;
  logic                  eng_busy;

  txe_byte_ram #(.BYTES(BUF_BYTES)) u_ram (
    .clk   (clk),
    .we    (host_we),
    .waddr (host_addr),
    .wdata (host_data),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  txe_reader #(.BYTES(BUF_BYTES), .DEPTH(STAT_DEPTH)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .wr_idx    (wr_idx),
    .slot_busy (stat_flags[stat_idx]),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_rdata (ram_rdata),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_last   (st_last),
    .tx_ok     (tx_ok),
    .stat_we   (stat_we),
    .stat_idx  (stat_idx),
    .stat_rec  (stat_rec),
    .ptr       (rd_ptr),
    .pkt_len   (pkt_len),
    .busy      (eng_busy)
  );

  txe_status_ring #(.DEPTH(STAT_DEPTH)) u_sr (
    .clk     (clk),
    .rst     (rst),
    .eng_we  (stat_we),
    .eng_idx (stat_idx),
    .eng_rec (stat_rec),
    .clr     (sr_clr),
    .clr_idx (sr_clr_idx),
    .rd_idx  (sr_rd_idx),
    .rd_flag (sr_rd_flag),
    .rd_rec  (rd_rec),
    .flags   (stat_flags)
  );

  assign st_data    = ram_rdata;
  assign sr_rd_size = rd_rec.size;
  assign sr_rd_ok   = rd_rec.ok;
endmodule

// File: rtl/txe_checker.sv
module txe_checker #(
  parameter int BUF_BYTES  = 8192,
  parameter int STAT_DEPTH = 64,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int SW = $clog2(STAT_DEPTH)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  st_valid,
  input logic                  st_ready,
  input logic                  st_last,
  input logic [7:0]            st_data,
  input logic [AW-3:0]         wr_idx,
  input logic [AW-1:0]         rd_ptr,
  input logic                  eng_busy,
  input logic [15:0]           pkt_len,
  input logic                  stat_we,
  input logic [SW-1:0]         stat_idx,
  input logic [STAT_DEPTH-1:0] stat_flags
);
  logic [16:0] beat_cnt;
  logic        hs;

  assign hs = st_valid && st_ready;

  always_ff @(posedge clk) begin
    if (rst)     beat_cnt <= '0;
    else if (hs) beat_cnt <= st_last ? 17'd0 : beat_cnt + 17'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!st_valid && (stat_flags == '0)));

  assert_start_gap_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(rd_ptr[AW-1:2] != wr_idx));

  assert_last_beat_R3: assert property (@(posedge clk) disable iff (rst)
    (hs && st_last) |-> ((beat_cnt + 17'd1) == {1'b0, pkt_len}));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));

  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
    stat_we |-> !stat_flags[stat_idx]);
endmodule

bind txbuf_engine txe_checker #(.BUF_BYTES(BUF_BYTES), .STAT_DEPTH(STAT_DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .st_last    (st_last),
  .st_data    (st_data),
  .wr_idx     (wr_idx),
  .rd_ptr     (rd_ptr),
  .eng_busy   (eng_busy),
  .pkt_len    (pkt_len),
  .stat_we    (stat_we),
  .stat_idx   (stat_idx),
  .stat_flags (stat_flags)
);

// File: tb/sim_txbuf_engine.sv
module sim_txbuf_engine;
  localparam int BUF = 64;
  localparam int DEP = 4;
  localparam int AW  = $clog2(BUF);
  localparam int SW  = $clog2(DEP);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]    host_data = '0;
  logic [AW-3:0] wr_idx = '0;
  logic [7:0]    st_data;
  logic          st_valid;
  logic          st_ready = 1'b0;
  logic          st_last;
  logic          tx_ok = 1'b0;
  logic          sr_clr = 1'b0;
  logic [SW-1:0] sr_clr_idx = '0;
  logic [SW-1:0] sr_rd_idx = '0;
  logic          sr_rd_flag;
  logic [15:0]   sr_rd_size;
  logic          sr_rd_ok;

  int checks = 0;
  int errors = 0;
  int hp = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txbuf_engine #(.BUF_BYTES(BUF), .STAT_DEPTH(DEP)) u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .wr_idx(wr_idx), .st_data(st_data),
    .st_valid(st_valid), .st_ready(st_ready), .st_last(st_last),
    .tx_ok(tx_ok), .sr_clr(sr_clr), .sr_clr_idx(sr_clr_idx),
    .sr_rd_idx(sr_rd_idx), .sr_rd_flag(sr_rd_flag),
    .sr_rd_size(sr_rd_size), .sr_rd_ok(sr_rd_ok)
  );

  function automatic logic [7:0] pay(int seed, int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hwr(input int a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(a % BUF); host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic put_pkt(input int len, input int seed);
    hwr(hp, 8'(len & 255));
    hwr(hp + 1, 8'((len >> 8) & 255));
    hwr(hp + 2, 8'hA5);
    hwr(hp + 3, 8'h3C);
    for (int i = 0; i < len; i++) hwr(hp + 4 + i, pay(seed, i));
    hp = ((hp + len + 7) & ~3) % BUF;
    @(negedge clk);
    wr_idx = (AW-2)'(hp >> 2);
  endtask

  task automatic take_pkt(input int len, input int seed, input int mode, input string req);
    int cnt = 0;
    int bad = 0;
    int holdbad = 0;
    int lastpos = -1;
    bit got = 0;
    bit pend = 0;
    logic [7:0] pdata = '0;
    for (int cyc = 0; cyc < 2000 && !got; cyc++) begin
      @(negedge clk);
      if (pend && (!st_valid || st_data != pdata)) holdbad++;
      st_ready = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : (cyc % 3 == 2);
      pend = st_valid && !st_ready;
      pdata = st_data;
      if (st_valid && st_ready) begin
        if (st_data != pay(seed, cnt)) bad++;
        if (st_last) begin lastpos = cnt; got = 1; end
        cnt++;
      end
    end
    @(negedge clk);
    st_ready = 1'b0;
    chk(bad == 0, {req, " payload bytes"}, bad, 0);
    chk(lastpos == len - 1, {req, " last position R3"}, lastpos, len - 1);
    if (mode != 0) chk(holdbad == 0, "R4 hold under backpressure", holdbad, 0);
  endtask

  task automatic rd_stat(input int idx, output logic f, output int sz, output logic ok);
    @(negedge clk);
    sr_rd_idx = SW'(idx);
    @(negedge clk);
    f = sr_rd_flag; sz = int'(sr_rd_size); ok = sr_rd_ok;
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    st_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (st_valid) seen++;
    end
    st_ready = 1'b0;
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic expect_entry(input int idx, input int sz, input logic ok, input string req);
    logic f, o;
    int s;
    repeat (3) @(negedge clk);
    rd_stat(idx, f, s, o);
    chk(f == 1'b1, {req, " flag"}, int'(f), 1);
    chk(s == sz, {req, " size"}, s, sz);
    chk(o == ok, {req, " success"}, int'(o), int'(ok));
  endtask

  task automatic t_reset;
    logic f, o;
    int s;
    chk(st_valid == 1'b0, "R1 st_valid after reset", int'(st_valid), 0);
    for (int i = 0; i < DEP; i++) begin
      rd_stat(i, f, s, o);
      chk(f == 1'b0, "R1 flag clear after reset", int'(f), 0);
    end
    quiet(10, "R2 no bytes while read pointer equals wr_idx");
  endtask

  task automatic t_basic;
    tx_ok = 1'b1;
    put_pkt(5, 1);
    take_pkt(5, 1, 0, "R3 basic record");
    expect_entry(0, 5, 1'b1, "R7 entry 0");
  endtask

  task automatic t_empty;
    put_pkt(0, 2);
    quiet(20, "R8 zero length sends nothing");
    expect_entry(1, 0, 1'b0, "R8 entry 1");
  endtask

  task automatic t_backpressure;
    tx_ok = 1'b0;
    put_pkt(40, 3);
    take_pkt(40, 3, 1, "R6 record after empty one");
    expect_entry(2, 40, 1'b0, "R7 entry 2 tx_ok low");
  endtask

  task automatic t_wrap_start;
    tx_ok = 1'b1;
    put_pkt(10, 4);
    take_pkt(10, 4, 2, "R5 payload starting at offset 0");
    expect_entry(3, 10, 1'b1, "R7 entry 3");
  endtask

  task automatic t_stall;
    logic f, o;
    int s;
    put_pkt(50, 5);
    quiet(30, "R9 stall while slot 0 flagged");
    @(negedge clk);
    sr_clr = 1'b1; sr_clr_idx = '0;
    @(negedge clk);
    sr_clr = 1'b0;
    rd_stat(0, f, s, o);
    chk(f == 1'b0, "R10 clear of entry 0", int'(f), 0);
    take_pkt(50, 5, 0, "R5 payload wrapping mid-record");
    expect_entry(0, 50, 1'b1, "R7 index wrap to entry 0");
    for (int i = 1; i < DEP; i++) begin
      rd_stat(i, f, s, o);
      chk(f == 1'b1, "R10 uncleared entries keep flag", int'(f), 1);
    end
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      finish_sim();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_empty();
    t_backpressure();
    t_wrap_start();
    t_stall();
    quiet(20, "R2 idle once all records are consumed");
    done = 1;
    finish_sim();
  end
endmodule